// File: doc/BRIEF.md
# Pulse-Distance Infrared Packet Transmitter

This block turns four active-high key inputs into infrared packets on one modulated output pin. Every symbol is a carrier burst of fixed length followed by a carrier-off gap. The length of the gap carries the symbol's meaning. A packet has seven gap-coded symbols and then one closing burst. The first symbol is a long-gap start mark. Next come the three bits of the pressed key's code. Then the same three bits follow again in inverted form, so a receiver can check them.

Each key is assigned a fixed three-bit code. When more than one key is active, the lowest-numbered key is selected. While the selected key is held, the packet is resent after a fixed pause. After the key is released, the block finishes the packet in flight and its pause, then returns to idle. Every timing is a whole number of ticks from a tick base derived from the clock. The carrier is a square wave whose half-period is also derived from the clock frequency.

Top module: `ir_pkt_tx`

## Requirements
- R1: While a burst is active, `ir_o` is a square wave. It is high for the first HALF = CLK_HZ/(2*CARRIER_HZ) cycles of every burst, then alternates every HALF cycles. It is low at every other time.
- R2: A tick lasts CLK_HZ/TICK_HZ cycles. Every burst lasts BURST_TICKS ticks (default 6).
- R3: After the start-mark burst the gap is HDR_GAP_TICKS (default 30). After a data burst carrying 1 the gap is ONE_GAP_TICKS (default 10). After a data burst carrying 0 the gap is ZERO_GAP_TICKS (default 20).
- R4: Symbol order is fixed. First the start mark, then code bits 0, 1, 2, then the inverse of code bits 0, 1, 2, then a final burst with no gap after it.
- R5: The codes are key 0 → 3'b001, key 1 → 3'b100, key 2 → 3'b101, key 3 → 3'b111, with bit 0 sent first. With several keys active, the lowest index is sent.
- R6: After the final burst comes a pause of PAUSE_TICKS (default 200) with `ir_o` low. If the selected key is still held when the pause ends, the next packet's first burst starts in the next cycle.
- R7: If the selected key is released, the packet in flight and its pause still complete. `busy_o` then falls and no further burst is sent.
- R8: `busy_o` is high from the first cycle of a packet's first burst to the last cycle of the pause.
- R9: During and straight after reset, `ir_o` and `busy_o` are low.
- R10: Keys pass through a two-flop synchroniser. Measured from a key change that lands between clock edges, `busy_o` rises on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| keys_i | input | 4 | Key inputs, active high, asynchronous |
| ir_o | output | 1 | Modulated carrier output |
| busy_o | output | 1 | High for the duration of each packet and its pause |

## Verification
The bench builds the block with CLK_HZ=400, TICK_HZ=100 and CARRIER_HZ=100. This makes a tick 4 cycles and a carrier half-period 2 cycles, and it leaves every tick count at its default. With these values a full packet and its pause take roughly 1500 cycles. That short length lets the bench sweep all fifteen non-zero key combinations, checking each burst and gap against its expected length cycle by cycle. Each combination covers one repeat, a release during the second packet, and the return to idle.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BURST, ST_GAP, ST_PAUSE} seq_st_e;

  localparam int unsigned NUM_KEYS = 4;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned SYM_W    = 3;
  localparam logic [SYM_W-1:0] SYM_STOP = 3'd7;

  function automatic logic [CODE_W-1:0] key_code(input logic [1:0] idx);
    case (idx)
      2'd0:    key_code = 3'b001;
      2'd1:    key_code = 3'b100;
      2'd2:    key_code = 3'b101;
      default: key_code = 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int unsigned DIV = 800,
  localparam int unsigned CW = $clog2(DIV + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int unsigned HALF = 105,
  localparam int unsigned CW = $clog2(HALF + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic carrier_o
);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);
  logic [CW-1:0] cnt_q;
  logic          ph_q;

  // phase rests high so every burst opens with a full high half-period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (!en_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign carrier_o = en_i & ph_q;
endmodule

// File: rtl/ir_key_select.sv
module ir_key_select #(
  parameter int unsigned NUM_KEYS = 4,
  localparam int unsigned IDX_W = $clog2(NUM_KEYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_KEYS-1:0] keys_i,
  output logic [NUM_KEYS-1:0] keys_s_o,
  output logic                any_o,
  output logic [IDX_W-1:0]    pri_o
);
  logic [NUM_KEYS-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= keys_i;
      s2_q <= s1_q;
    end
  end

  // lowest index wins
  always_comb begin
    pri_o = '0;
    for (int i = NUM_KEYS - 1; i >= 0; i--)
      if (s2_q[i]) pri_o = IDX_W'(i);
  end

  assign keys_s_o = s2_q;
  assign any_o    = |s2_q;
endmodule

// File: rtl/ir_sym_seq.sv
module ir_sym_seq
  import ir_tx_pkg::*;
#(
  parameter int unsigned BURST_TICKS    = 6,
  parameter int unsigned HDR_GAP_TICKS  = 30,
  parameter int unsigned ONE_GAP_TICKS  = 10,
  parameter int unsigned ZERO_GAP_TICKS = 20,
  parameter int unsigned PAUSE_TICKS    = 200,
  localparam int unsigned IDX_W = $clog2(NUM_KEYS),
  localparam int unsigned MAX_T =
    (PAUSE_TICKS > HDR_GAP_TICKS) ? PAUSE_TICKS : HDR_GAP_TICKS,
  localparam int unsigned TK_W = $clog2(MAX_T + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [NUM_KEYS-1:0] keys_s_i,
  input  logic                any_i,
  input  logic [IDX_W-1:0]    pri_i,
  output seq_st_e             st_o,
  output logic [SYM_W-1:0]    sym_o,
  output logic [CODE_W-1:0]   code_o,
  output logic                burst_o,
  output logic                clr_o,
  output logic                busy_o
);
  localparam logic [TK_W-1:0] BURST_LAST = TK_W'(BURST_TICKS - 1);
  localparam logic [TK_W-1:0] HDR_LAST   = TK_W'(HDR_GAP_TICKS - 1);
  localparam logic [TK_W-1:0] ONE_LAST   = TK_W'(ONE_GAP_TICKS - 1);
  localparam logic [TK_W-1:0] ZERO_LAST  = TK_W'(ZERO_GAP_TICKS - 1);
  localparam logic [TK_W-1:0] PAUSE_LAST = TK_W'(PAUSE_TICKS - 1);

  seq_st_e           st_q;
  logic [SYM_W-1:0]  sym_q;
  logic [TK_W-1:0]   tk_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CODE_W-1:0] code_q;
  logic              data_bit;
  logic [TK_W-1:0]   gap_last;

  always_comb begin
    data_bit = 1'b0;
    if (sym_q >= 3'd1 && sym_q <= 3'd3)
      data_bit = code_q[2'(sym_q - 3'd1)];
    else if (sym_q >= 3'd4 && sym_q <= 3'd6)
      data_bit = ~code_q[2'(sym_q - 3'd4)];
    if (sym_q == 3'd0) gap_last = HDR_LAST;
    else               gap_last = data_bit ? ONE_LAST : ZERO_LAST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sym_q  <= '0;
      tk_q   <= '0;
      idx_q  <= '0;
      code_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (any_i) begin
          st_q   <= ST_BURST;
          sym_q  <= '0;
          tk_q   <= '0;
          idx_q  <= pri_i;
          code_q <= key_code(2'(pri_i));
        end
        ST_BURST: if (tick_i) begin
          if (tk_q == BURST_LAST) begin
            tk_q <= '0;
            st_q <= (sym_q == SYM_STOP) ? ST_PAUSE : ST_GAP;
          end else tk_q <= tk_q + 1'b1;
        end
        ST_GAP: if (tick_i) begin
          if (tk_q == gap_last) begin
            tk_q  <= '0;
            sym_q <= sym_q + 1'b1;
            st_q  <= ST_BURST;
          end else tk_q <= tk_q + 1'b1;
        end
        ST_PAUSE: if (tick_i) begin
          if (tk_q == PAUSE_LAST) begin
            tk_q  <= '0;
            sym_q <= '0;
            st_q  <= keys_s_i[idx_q] ? ST_BURST : ST_IDLE;
          end else tk_q <= tk_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o    = st_q;
  assign sym_o   = sym_q;
  assign code_o  = code_q;
  assign burst_o = (st_q == ST_BURST);
  assign clr_o   = (st_q == ST_IDLE);
  assign busy_o  = (st_q != ST_IDLE);
endmodule

// File: rtl/ir_pkt_tx.sv
module ir_pkt_tx
  import ir_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ         = 8_000_000,
  parameter int unsigned TICK_HZ        = 10_000,
  parameter int unsigned CARRIER_HZ     = 38_000,
  parameter int unsigned BURST_TICKS    = 6,
  parameter int unsigned HDR_GAP_TICKS  = 30,
  parameter int unsigned ONE_GAP_TICKS  = 10,
  parameter int unsigned ZERO_GAP_TICKS = 20,
  parameter int unsigned PAUSE_TICKS    = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] keys_i,
  output logic       ir_o,
  output logic       busy_o
);
  localparam int unsigned TICK_DIV = CLK_HZ / TICK_HZ;
  localparam int unsigned HALF_CYC = CLK_HZ / (2 * CARRIER_HZ);
  localparam int unsigned IDX_W    = $clog2(NUM_KEYS);

  logic [NUM_KEYS-1:0] keys_s;
  logic                any_key;
  logic [IDX_W-1:0]    pri_idx;
  logic                tick;
  logic                clr;
  logic                burst;
  seq_st_e             st_w;
  logic [SYM_W-1:0]    sym_w;
  logic [CODE_W-1:0]   code_w;

  ir_key_select #(.NUM_KEYS(NUM_KEYS)) u_keys (
    .clk_i, .rst_ni, .keys_i,
    .keys_s_o(keys_s), .any_o(any_key), .pri_o(pri_idx)
  );

  ir_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i, .rst_ni, .clr_i(clr), .tick_o(tick)
  );

  ir_sym_seq #(
    .BURST_TICKS(BURST_TICKS), .HDR_GAP_TICKS(HDR_GAP_TICKS),
    .ONE_GAP_TICKS(ONE_GAP_TICKS), .ZERO_GAP_TICKS(ZERO_GAP_TICKS),
    .PAUSE_TICKS(PAUSE_TICKS)
  ) u_seq (
    .clk_i, .rst_ni, .tick_i(tick), .keys_s_i(keys_s), .any_i(any_key),
    .pri_i(pri_idx), .st_o(st_w), .sym_o(sym_w), .code_o(code_w),
    .burst_o(burst), .clr_o(clr), .busy_o
  );

  ir_carrier_gen #(.HALF(HALF_CYC)) u_car (
    .clk_i, .rst_ni, .en_i(burst), .carrier_o(ir_o)
  );
endmodule

// File: rtl/ir_pkt_tx_chk.sv
module ir_pkt_tx_chk
  import ir_tx_pkg::*;
#(
  parameter int unsigned HALF = 105
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ir_o,
  input logic              busy_o,
  input seq_st_e           st_w,
  input logic [SYM_W-1:0]  sym_w,
  input logic [CODE_W-1:0] code_w
);
  logic [15:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_q <= '0;
    else if (ir_o) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  AST_IR_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ir_o); // R1
  AST_HIGH_RUN_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_o |-> (run_q < 16'(HALF))); // R1
  AST_BUSY_OPENS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ir_o); // R8
  AST_SYM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_w != $past(sym_w)) |-> ((sym_w == $past(sym_w) + 3'd1) || (sym_w == 3'd0))); // R4
  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(code_w)); // R5
  AST_END_AFTER_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(st_w) == ST_PAUSE)); // R7
endmodule

bind ir_pkt_tx ir_pkt_tx_chk #(.HALF(HALF_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ir_o(ir_o), .busy_o(busy_o),
  .st_w(st_w), .sym_w(sym_w), .code_w(code_w)
);

// File: tb/test_ir_pkt_tx.sv
`timescale 1ns/1ps
module test_ir_pkt_tx;
  localparam int DIV   = 4;
  localparam int HALF  = 2;
  localparam int BT    = 6;
  localparam int HDR   = 30;
  localparam int ONE   = 10;
  localparam int ZERO  = 20;
  localparam int PAUSE = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] keys = '0;
  logic       ir, busy;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  ir_pkt_tx #(.CLK_HZ(400), .TICK_HZ(100), .CARRIER_HZ(100)) i_ir_pkt_tx (
    .clk_i(clk), .rst_ni(rst_n), .keys_i(keys), .ir_o(ir), .busy_o(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // burst: ir follows carrier pattern, busy high; R1 R2
  task automatic chk_burst(input string req);
    int bad = 0;
    for (int c = 0; c < BT * DIV; c++) begin
      if (ir !== (((c / HALF) % 2) == 0)) bad++;
      if (busy !== 1'b1) bad++;
      @(negedge clk);
    end
    check(req, bad, 0);
  endtask

  // carrier-off interval of n ticks with busy high
  task automatic chk_quiet(input string req, input int ticks);
    int bad = 0;
    for (int c = 0; c < ticks * DIV; c++) begin
      if (ir !== 1'b0 || busy !== 1'b1) bad++;
      @(negedge clk);
    end
    check(req, bad, 0);
  endtask

  // one full packet starting at burst cycle 0, plus its pause
  task automatic chk_packet(input int code);
    int b;
    chk_burst("R2 start burst");
    chk_quiet("R3 start gap", HDR);
    for (int s = 1; s <= 6; s++) begin
      b = (s <= 3) ? ((code >> (s - 1)) & 1) : (((code >> (s - 4)) & 1) ^ 1);
      chk_burst("R4 data burst");
      chk_quiet(b ? "R3 R5 gap one" : "R3 R5 gap zero", b ? ONE : ZERO);
    end
    chk_burst("R4 final burst");
    chk_quiet("R6 R8 pause", PAUSE);
  endtask

  initial begin
    automatic int codes[4] = '{1, 4, 5, 7};
    automatic int k;
    repeat (3) @(negedge clk);
    check("R9 ir in reset", ir, 0);
    check("R9 busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ir after reset", ir, 0);
    check("R9 busy after reset", busy, 0);
    for (int m = 1; m < 16; m++) begin
      k = 0;
      while (((m >> k) & 1) == 0) k++;
      keys = 4'(m);
      @(negedge clk);
      @(negedge clk);
      check("R10 busy before sync", busy, 0);
      @(negedge clk);
      check("R10 busy on third edge", busy, 1);
      chk_packet(codes[k]);
      check("R6 repeat starts", busy, 1);
      check("R6 repeat burst high", ir, 1);
      keys = '0;
      chk_packet(codes[k]);
      check("R7 busy after release", busy, 0);
      for (int c = 0; c < 10; c++) begin
        check("R7 no burst after release", ir, 0);
        @(negedge clk);
      end
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) check("watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule